// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block creates the reset line that a supply supervisor hands to a processor. It watches two digital causes: a flag that reads true while the monitored supply sits below its trip level, and an active-low request from a push-button or from another block. While either cause is present, reset is driven. Once both have gone away, reset is kept for a fixed number of prescaled time ticks before it is released.

The block has no separate debounce filter. A contact that bounces keeps pulling the request low, and every low level restarts the hold count, so reset is released only after the input has been quiet for a whole hold period. Two outputs carry the same reset in opposite polarities, one for active-low loads and one for active-high loads. Time is counted only on a single-cycle `tick` strobe from a shared prescaler. A supervisor with a nominal 200 ms hold and a 1 ms tick uses `HOLD_TICKS = 200`.

A watchdog that should reset the processor is wired into the manual request input outside this block. The block itself has no other way to assert reset.

Top module: `supv_reset_gen`

## Requirements
- R1: Coming out of the asynchronous power-up reset, `rst_out_n` is 0. It stays 0 until `HOLD_TICKS` tick strobes have been counted with both causes inactive.
- R2: While `supply_low` is 1, `rst_out_n` stays 0 on every cycle.
- R3: Once `supply_low` returns to 0 with `man_rst_n` high, `rst_out_n` goes to 1 exactly when the `HOLD_TICKS`-th later tick strobe has been counted.
- R4: A low level on `man_rst_n`, even one lasting a single cycle, drives `rst_out_n` to 0.
- R5: After `man_rst_n` returns high, `rst_out_n` stays 0 for the full `HOLD_TICKS` tick strobes.
- R6: A new low level on either cause during a hold period reloads the full count. Bounce on `man_rst_n` therefore extends the reset and never shortens it.
- R7: `rst_out` always equals the inverse of `rst_out_n`.
- R8: The hold count advances only on cycles where `tick` is 1. With no strobes, reset is held indefinitely.
- R9: Each input passes through a two-flop synchroniser. A change sampled at a rising edge reaches the outputs after the third rising edge, counting that edge as the first.
- R10: With `supply_low` at 0 and `man_rst_n` at 1, no `tick` activity asserts reset. Only the two causes can assert it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tick | input | 1 | Single-cycle prescaler strobe that advances the hold count |
| supply_low | input | 1 | 1 while the monitored supply is below its trip level |
| man_rst_n | input | 1 | Manual or external reset request, active low, may bounce |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high, the inverse of `rst_out_n` |

## Verification
The properties assume the following about the inputs:
- `tick` is a strobe that is 1 for single cycles.
- `supply_low` and `man_rst_n` change between clock edges, so each change is sampled cleanly by the first synchroniser flop.

The latency properties count three edges from a sampled cause to the outputs, which matches the two synchroniser stages and the hold register. The stimulus meets these assumptions:
- The bench drives every input on the falling edge.
- It pulses `tick` for one cycle at a time.
- It includes stretches with no ticks at all, single-cycle pulses on both causes, and bounce trains on the manual input.

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_low,
  input  logic man_rst_n,
  output logic rst_out_n,
  output logic rst_out
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

  logic [1:0]    low_sync;
  logic [1:0]    req_sync;
  logic [CW-1:0] hold_cnt;
  logic          cause;

  // synchronisers come out of reset in the asserting state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_sync <= 2'b11;
      req_sync <= 2'b11;
    end else begin
      low_sync <= {low_sync[0], supply_low};
      req_sync <= {req_sync[0], ~man_rst_n};
    end
  end

  assign cause = low_sync[1] | req_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_cnt <= FULL;
    else if (cause)                   hold_cnt <= FULL;
    else if (tick && hold_cnt != '0)  hold_cnt <= hold_cnt - CW'(1);
  end

  assign rst_out_n = (hold_cnt == '0);
  assign rst_out   = ~rst_out_n;
endmodule

module supv_reset_gen_check (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_low,
  input logic man_rst_n,
  input logic rst_out_n,
  input logic rst_out
);
  p_complement_r7: assert property (@(posedge clk) rst_out == ~rst_out_n);

  p_low_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low, 3) |-> !rst_out_n);

  p_manual_asserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(man_rst_n, 3) |-> !rst_out_n);

  p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick));

  p_only_causes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> ($past(supply_low, 3) || !$past(man_rst_n, 3)));
endmodule

bind supv_reset_gen supv_reset_gen_check u_check (.*);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic supply_low = 1'b0;
  logic man_rst_n = 1'b1;
  logic rst_out_n, rst_out;

  int vectors = 0;
  int errors = 0;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_gen #(.HOLD_TICKS(HOLD)) u_supv_reset_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
    .man_rst_n(man_rst_n), .rst_out_n(rst_out_n), .rst_out(rst_out)
  );

  // reference: inputs ride a two-deep queue, then a remaining-tick integer
  bit q_cause[$];
  int remaining;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cause = '{1'b1, 1'b1};
      remaining = HOLD;
    end else begin
      if (q_cause[0]) remaining = HOLD;
      else if (tick && remaining > 0) remaining = remaining - 1;
      void'(q_cause.pop_front());
      q_cause.push_back(supply_low || !man_rst_n);
    end
  end

  task automatic step(input bit lo, input bit mr_n, input bit tk);
    logic exp_n;
    @(negedge clk);
    exp_n = (remaining == 0);
    vectors++;
    if (rst_out_n !== exp_n) begin
      errors++;
      $display("FAIL %s: rst_out_n actual=%b expected=%b at %0t", req, rst_out_n, exp_n, $time);
    end
    vectors++;
    if (rst_out !== ~exp_n) begin
      errors++;
      $display("FAIL R7: rst_out actual=%b expected=%b at %0t", rst_out, ~exp_n, $time);
    end
    supply_low = lo;
    man_rst_n = mr_n;
    tick = tk;
  endtask

  task automatic run(input int n, input bit lo, input bit mr_n, input int tick_every);
    for (int i = 0; i < n; i++)
      step(lo, mr_n, tick_every > 0 && (i % tick_every) == 0);
  endtask

  initial begin
    req = "R1";
    run(3, 0, 1, 2);
    rst_n = 1'b1;
    run(20, 0, 1, 2);
    req = "R10";
    run(15, 0, 1, 1);
    req = "R2";
    run(20, 1, 1, 2);
    req = "R3";
    run(20, 0, 1, 3);
    req = "R9";
    run(1, 1, 1, 0);
    run(6, 0, 1, 0);
    run(16, 0, 1, 2);
    req = "R4";
    run(1, 0, 0, 2);
    run(3, 0, 1, 0);
    req = "R5";
    run(16, 0, 1, 2);
    req = "R6";
    run(2, 0, 0, 1);
    run(5, 0, 1, 1);
    run(1, 0, 0, 1);
    run(3, 0, 1, 1);
    run(1, 1, 1, 1);
    run(25, 0, 1, 2);
    req = "R8";
    run(2, 1, 1, 0);
    run(30, 0, 1, 0);
    run(15, 0, 1, 2);
    req = "R1";
    rst_n = 1'b0;
    run(3, 0, 1, 2);
    rst_n = 1'b1;
    run(20, 0, 1, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule